// File: doc/BRIEF.md
# Temperature Alarm Threshold Comparator

This block holds two signed 8-bit limit bytes, an upper and a lower trip point, and compares each fresh temperature reading against them. A single-cycle completion strobe from the measurement logic presents a 16-bit two's-complement fixed-point temperature with four fraction bits. Only the whole-degree part of that word, bits [11:4], enters the comparison. The fraction is dropped, and the upper bits only carry the sign extension.

The alarm flag is rebuilt from scratch on every reading, so it tracks the most recent measurement and is not a sticky latch. A second output, which always equals the flag, tells the bus command layer whether this device should take part in a conditional search that only devices in alarm answer. Two write enables that share one data byte load the limits. A new limit applies from the next reading onward.

Top module: `temp_alarm_cmp`

## Requirements
- R1: While reset (rst_n low) is asserted, and after it is released, `alarm` and `search_respond` read 0 until the first reading is strobed.
- R2: On the clock edge that samples `conv_done` high, `alarm` becomes 1 if the signed value of `temp_word[11:4]` is strictly greater than the signed high limit.
- R3: On that same edge, `alarm` becomes 1 if the signed value of `temp_word[11:4]` is strictly less than the signed low limit.
- R4: A whole-degree value equal to the high limit or equal to the low limit does not raise the alarm.
- R5: Fraction bits `temp_word[3:0]` have no effect. A value equal to the high limit with fraction 4'hF does not raise the alarm.
- R6: The comparison is two's complement. Bit 7 of each limit byte is its sign and lines up with the temperature sign. For example, high limit 8'hF6 (-10) with a reading of -5 raises the alarm.
- R7: Each reading rewrites the flag. A reading back inside the limits clears an alarm that was set earlier.
- R8: In cycles without `conv_done`, `alarm` holds its value. A limit write does not re-evaluate the stored reading.
- R9: A limit write sampled on the same edge as `conv_done` is not used for that reading. It applies from the next reading.
- R10: `search_respond` equals `alarm` at all times: 1 means answer the alarm-conditional search, and 0 means stay silent.
- R11: `hi_wr` loads `lim_data` into the high limit and `lo_wr` loads it into the low limit. The reset values are high = 8'h7F and low = 8'h80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe: `temp_word` holds a new reading |
| temp_word | input | 16 | Signed fixed-point temperature, 4 fraction bits |
| hi_wr | input | 1 | Load `lim_data` into the high limit |
| lo_wr | input | 1 | Load `lim_data` into the low limit |
| lim_data | input | 8 | Signed limit byte to write |
| alarm | output | 1 | Reading outside the limits |
| search_respond | output | 1 | Answer the alarm-conditional search |

## Verification
Both `alarm` and `search_respond` are due one clock edge after the strobe is sampled. A limit write becomes visible only through the result of the next strobe. The bench drives all inputs on the falling edge and samples the outputs on the following falling edge, so every sample falls half a cycle after the one register stage. Its reference model records the limits in force at each strobe before it applies any write from the same cycle. Cycles without a strobe are checked for an unchanged flag.

// File: rtl/temp_alarm_pkg.sv
package temp_alarm_pkg;

   // Index of each limit inside the limit bank
   typedef enum logic [0:0] {
      LIM_HI = 1'b0,
      LIM_LO = 1'b1
   } lim_sel_e;

   localparam int NUM_LIMITS = 2;

endpackage

// File: rtl/tac_limit_bank.sv
module tac_limit_bank #(
   parameter int            LIM_W  = 8,
   parameter logic [LIM_W-1:0] HI_RST = 8'h7F,
   parameter logic [LIM_W-1:0] LO_RST = 8'h80
) (
   input  logic                                              clk,
   input  logic                                              rst_n,
   input  logic [temp_alarm_pkg::NUM_LIMITS-1:0]             wr_en,
   input  logic [LIM_W-1:0]                                  wr_data,
   output logic [temp_alarm_pkg::NUM_LIMITS-1:0][LIM_W-1:0]  lim_q
);
   import temp_alarm_pkg::*;

   for (genvar g = 0; g < NUM_LIMITS; g++) begin : g_lim
      localparam logic [LIM_W-1:0] RST_VAL = (g == int'(LIM_HI)) ? HI_RST : LO_RST;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lim_q[g] <= RST_VAL;
         end else if (wr_en[g]) begin
            lim_q[g] <= wr_data;
         end
      end
   end

endmodule

// File: rtl/tac_int_field.sv
module tac_int_field #(
   parameter int TEMP_W = 16,
   parameter int FRAC_W = 4,
   parameter int LIM_W  = 8
) (
   input  logic [TEMP_W-1:0] temp_word,
   output logic [LIM_W-1:0]  int_part
);
   localparam int INT_LSB = FRAC_W;
   localparam int INT_MSB = FRAC_W + LIM_W - 1;
   localparam int EXT_W   = TEMP_W - INT_MSB - 1;

   if (INT_MSB >= TEMP_W) begin : g_bad
      $error("tac_int_field: FRAC_W + LIM_W exceeds TEMP_W");
   end

   assign int_part = temp_word[INT_MSB:INT_LSB];

   // Fraction and sign-extension bits take no part in the comparison
   if (FRAC_W > 0 && EXT_W > 0) begin : g_both
      logic unused_bits;
      assign unused_bits = &{1'b0, temp_word[TEMP_W-1:INT_MSB+1], temp_word[INT_LSB-1:0]};
   end else if (FRAC_W > 0) begin : g_frac
      logic unused_bits;
      assign unused_bits = &{1'b0, temp_word[INT_LSB-1:0]};
   end else if (EXT_W > 0) begin : g_ext
      logic unused_bits;
      assign unused_bits = &{1'b0, temp_word[TEMP_W-1:INT_MSB+1]};
   end

endmodule

// File: rtl/tac_window_cmp.sv
module tac_window_cmp #(
   parameter int LIM_W = 8
) (
   input  logic [LIM_W-1:0] value,
   input  logic [LIM_W-1:0] hi_lim,
   input  logic [LIM_W-1:0] lo_lim,
   output logic             above,
   output logic             below,
   output logic             outside
);
   if (LIM_W < 2) begin : g_bad
      $error("tac_window_cmp: LIM_W must be at least 2");
   end

   always_comb begin
      above   = $signed(value) > $signed(hi_lim);
      below   = $signed(value) < $signed(lo_lim);
      outside = above | below;
   end

endmodule

// File: rtl/temp_alarm_cmp.sv
module temp_alarm_cmp #(
   parameter int               TEMP_W = 16,
   parameter int               FRAC_W = 4,
   parameter int               LIM_W  = 8,
   parameter logic [LIM_W-1:0] HI_RST = 8'h7F,
   parameter logic [LIM_W-1:0] LO_RST = 8'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_done,
   input  logic [TEMP_W-1:0] temp_word,
   input  logic              hi_wr,
   input  logic              lo_wr,
   input  logic [LIM_W-1:0]  lim_data,
   output logic              alarm,
   output logic              search_respond
);
   import temp_alarm_pkg::*;

   logic [NUM_LIMITS-1:0]            lim_wr;
   logic [NUM_LIMITS-1:0][LIM_W-1:0] lim_q;
   logic [LIM_W-1:0]                 hi_lim;
   logic [LIM_W-1:0]                 lo_lim;
   logic [LIM_W-1:0]                 int_part;
   logic                             above;
   logic                             below;
   logic                             outside;
   logic                             flag_q;

   always_comb begin
      lim_wr         = '0;
      lim_wr[LIM_HI] = hi_wr;
      lim_wr[LIM_LO] = lo_wr;
   end

   tac_limit_bank #(
      .LIM_W  (LIM_W),
      .HI_RST (HI_RST),
      .LO_RST (LO_RST)
   ) u_limits (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (lim_wr),
      .wr_data (lim_data),
      .lim_q   (lim_q)
   );

   assign hi_lim = lim_q[LIM_HI];
   assign lo_lim = lim_q[LIM_LO];

   tac_int_field #(
      .TEMP_W (TEMP_W),
      .FRAC_W (FRAC_W),
      .LIM_W  (LIM_W)
   ) u_field (
      .temp_word (temp_word),
      .int_part  (int_part)
   );

   tac_window_cmp #(
      .LIM_W (LIM_W)
   ) u_cmp (
      .value   (int_part),
      .hi_lim  (hi_lim),
      .lo_lim  (lo_lim),
      .above   (above),
      .below   (below),
      .outside (outside)
   );

   // Flag rebuilt on every reading; limits used are those held before this edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (conv_done) begin
         flag_q <= outside;
      end
   end

   assign alarm          = flag_q;
   assign search_respond = flag_q;

endmodule

// File: rtl/tac_alarm_chk.sv
module tac_alarm_chk #(
   parameter int TEMP_W = 16,
   parameter int FRAC_W = 4,
   parameter int LIM_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              conv_done,
   input logic [TEMP_W-1:0] temp_word,
   input logic [LIM_W-1:0]  hi_lim,
   input logic [LIM_W-1:0]  lo_lim,
   input logic              alarm,
   input logic              search_respond
);
   logic [LIM_W-1:0] t_int;
   assign t_int = temp_word[FRAC_W+LIM_W-1:FRAC_W];

   // R1
   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> !alarm && !search_respond);

   // R2, R3, R4, R9: result reflects the reading and the limits held at the strobe
   assert_flag_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |=> alarm == (($signed($past(t_int)) > $signed($past(hi_lim))) ||
                              ($signed($past(t_int)) < $signed($past(lo_lim)))));

   // R8
   assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_done |=> $stable(alarm));

   // R10
   assert_respond_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(search_respond) |-> $past(conv_done));

   assert_respond_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_done |=> $stable(search_respond));

endmodule

bind temp_alarm_cmp tac_alarm_chk #(
   .TEMP_W (TEMP_W),
   .FRAC_W (FRAC_W),
   .LIM_W  (LIM_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .conv_done      (conv_done),
   .temp_word      (temp_word),
   .hi_lim         (hi_lim),
   .lo_lim         (lo_lim),
   .alarm          (alarm),
   .search_respond (search_respond)
);

// File: tb/temp_alarm_cmp_tb.sv
module temp_alarm_cmp_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        conv_done = 1'b0;
   logic [15:0] temp_word = '0;
   logic        hi_wr = 1'b0;
   logic        lo_wr = 1'b0;
   logic [7:0]  lim_data = '0;
   logic        alarm;
   logic        search_respond;

   int errors = 0;
   int checks = 0;
   logic [7:0] m_hi = 8'h7F;
   logic [7:0] m_lo = 8'h80;
   logic       m_alarm = 1'b0;
   bit         done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   temp_alarm_cmp u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .conv_done      (conv_done),
      .temp_word      (temp_word),
      .hi_wr          (hi_wr),
      .lo_wr          (lo_wr),
      .lim_data       (lim_data),
      .alarm          (alarm),
      .search_respond (search_respond)
   );

   function automatic logic exp_alarm(input int deg, input logic [7:0] hi, input logic [7:0] lo);
      return (deg > int'($signed(hi))) || (deg < int'($signed(lo)));
   endfunction

   function automatic logic [15:0] mk_temp(input int deg, input int frac);
      logic [15:0] w;
      w = 16'(deg * 16);
      w[3:0] = 4'(frac);
      return w;
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   // Strobe one reading, optionally with a limit write in the same cycle.
   task automatic convert(input string req, input int deg, input int frac,
                          input logic whi, input logic wlo, input logic [7:0] d);
      @(negedge clk);
      conv_done = 1'b1;
      temp_word = mk_temp(deg, frac);
      hi_wr = whi; lo_wr = wlo; lim_data = d;
      m_alarm = exp_alarm(deg, m_hi, m_lo);
      if (whi) m_hi = d;
      if (wlo) m_lo = d;
      @(negedge clk);
      conv_done = 1'b0; hi_wr = 1'b0; lo_wr = 1'b0;
      temp_word = 16'hA5A5;
      check(req, alarm, m_alarm);
      check("R10", search_respond, m_alarm);
   endtask

   task automatic write_lim(input logic whi, input logic wlo, input logic [7:0] d);
      @(negedge clk);
      hi_wr = whi; lo_wr = wlo; lim_data = d;
      if (whi) m_hi = d;
      if (wlo) m_lo = d;
      @(negedge clk);
      hi_wr = 1'b0; lo_wr = 1'b0;
      check("R8", alarm, m_alarm);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1", alarm, 1'b0);
      check("R1", search_respond, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", alarm, 1'b0);

      // R11: reset limits are +127 / -128, so no reading trips
      convert("R11", 127, 15, 1'b0, 1'b0, 8'h00);
      convert("R11", -128, 0, 1'b0, 1'b0, 8'h00);

      write_lim(1'b1, 1'b0, 8'd25);
      write_lim(1'b0, 1'b1, 8'hF6);  // low = -10
      convert("R2", 26, 0, 1'b0, 1'b0, 8'h00);
      convert("R7", 20, 3, 1'b0, 1'b0, 8'h00);
      convert("R4", 25, 0, 1'b0, 1'b0, 8'h00);
      convert("R5", 25, 15, 1'b0, 1'b0, 8'h00);
      convert("R4", -10, 0, 1'b0, 1'b0, 8'h00);
      convert("R3", -11, 15, 1'b0, 1'b0, 8'h00);
      // R8: limit writes while alarm set leave it untouched
      write_lim(1'b0, 1'b1, 8'h80);
      write_lim(1'b1, 1'b0, 8'h7F);
      repeat (3) begin
         @(negedge clk);
         check("R8", alarm, m_alarm);
      end
      // R6: negative high limit
      write_lim(1'b1, 1'b0, 8'hF6);
      convert("R6", -5, 0, 1'b0, 1'b0, 8'h00);
      convert("R6", -10, 8, 1'b0, 1'b0, 8'h00);
      // R9: write with strobe uses old limit
      convert("R9", 0, 0, 1'b1, 1'b0, 8'd50);
      convert("R9", 0, 0, 1'b0, 1'b0, 8'h00);
      convert("R9", 10, 0, 1'b0, 1'b1, 8'd20);
      convert("R9", 10, 0, 1'b0, 1'b0, 8'h00);
      write_lim(1'b1, 1'b1, 8'd5);
      convert("R11", 5, 0, 1'b0, 1'b0, 8'h00);
      convert("R11", 6, 0, 1'b0, 1'b0, 8'h00);

      // Constrained random mix
      void'($urandom(32'd1234));
      for (int i = 0; i < 400; i++) begin
         int sel;
         sel = int'($urandom_range(0, 9));
         if (sel < 2) begin
            write_lim(sel == 0, sel == 1, 8'($urandom_range(0, 255)));
         end else begin
            int deg;
            deg = int'($urandom_range(0, 255)) - 128;
            convert("R7", deg, int'($urandom_range(0, 15)),
                    ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
                    8'($urandom_range(0, 255)));
         end
      end
      done = 1'b1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < WATCHDOG) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule